// File: doc/BRIEF.md
# Chainable Up-Counter with Programmable Wrap and Restart

This block is a synchronous binary up-counter, four bits wide by default. Several copies can be joined into a wider counter. Each stage has two count enables. Its carry output is gated by one of them and feeds the enable of the next stage up. As a result, every stage of a chain moves on the same rising clock edge.

Two mode bits change where a stage wraps and what it wraps to:

- **End mode.** A comparator replaces the all-ones wrap point with a programmed end value.
- **Restart mode.** At a wrap, the counter takes a programmed start value instead of zero.

Used together, the two modes make the count cycle between any start value and any end value. A synchronous clear and a synchronous parallel load override counting, and both act even when the enables are low.

Top module: `chain_counter`

## Requirements
- R1: When `rst` or `clr` is high at a rising edge, `count` becomes 0 after that edge, whatever `load` and the enables are.
- R2: When `load` is high and `rst`/`clr` are low, `count` takes `load_val` (bit 3 = MSB) at the edge, even with both enables low.
- R3: With no clear or load, `count` keeps its value whenever `en_p` or `en_t` is low.
- R4: With no clear or load, and with both enables high, `count` increases by one at each edge unless it sits at the wrap point.
- R5: With `end_mode` low, the wrap point is 1111. With `restart_mode` also low, an enabled edge at 1111 yields 0000.
- R6: `carry_out` is combinational and equals `en_t` AND (count is at the wrap point). It does not depend on `en_p`.
- R7: With `restart_mode` high, an enabled edge at the wrap point loads `start_val` instead of 0000 (for example 0110, 0111, …, 1111, 0110).
- R8: With `end_mode` high, the wrap point is `end_val`. At that point an enabled edge goes to 0000, or to `start_val` in restart mode. A count above `end_val` keeps counting and rolls from 1111 to 0000 without a carry.
- R9: When the `carry_out` of a low stage drives the `en_t` of a high stage, the high stage increments on the same edge on which the low stage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear to zero |
| load | input | 1 | Synchronous parallel load strobe |
| load_val | input | WIDTH | Value taken on load |
| en_p | input | 1 | Count enable, local only |
| en_t | input | 1 | Count enable, also gates carry |
| restart_mode | input | 1 | Wrap to start_val instead of zero |
| end_mode | input | 1 | Wrap at end_val instead of all ones |
| start_val | input | WIDTH | Restart value |
| end_val | input | WIDTH | Programmed wrap point |
| count | output | WIDTH | Registered count |
| carry_out | output | 1 | Carry to the next stage |

## Verification
Long stretches of random enables are run with only rare clears and loads. These stretches separate plain incrementing from holding, and they show whether each of the two enables alone stops the count. Every 64 cycles the mode bits and the start and end values are redrawn. Together with random loads, including loads above the end value, this reaches all four wrap variants and the roll-over past the end value. Directed runs cover the following:

- the plain 1111 wrap;
- the 0110 restart cycle;
- the 1101 end cycle;
- a load with both enables low.

A second stage is chained through the carry. It shows whether carry timing and the `en_t` gating line up with the wrap of the low stage.

// File: rtl/chain_counter_pkg.sv
package chain_counter_pkg;
  typedef enum logic [1:0] {
    SEL_CLEAR = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_STEP  = 2'd2,
    SEL_HOLD  = 2'd3
  } next_sel_e;
endpackage

// File: rtl/chain_wrap_detect.sv
module chain_wrap_detect #(
  parameter int WIDTH       = 4,
  parameter bit HAS_OFFSETS = 1'b1
) (
  input  logic [WIDTH-1:0] count,
  input  logic [WIDTH-1:0] end_val,
  input  logic             end_mode,
  output logic             at_wrap
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  generate
    if (HAS_OFFSETS) begin : g_cmp
      always_comb begin
        if (end_mode) at_wrap = (count == end_val);
        else          at_wrap = &count;
      end
    end else begin : g_fixed
      logic unused_cfg;
      assign unused_cfg = end_mode ^ (^end_val);
      assign at_wrap = (count == ALL_ONES);
    end
  endgenerate
endmodule

// File: rtl/chain_next_select.sv
module chain_next_select
  import chain_counter_pkg::*;
(
  input  logic      rst,
  input  logic      clr,
  input  logic      load,
  input  logic      en_p,
  input  logic      en_t,
  output next_sel_e sel
);
  always_comb begin
    if (rst || clr)        sel = SEL_CLEAR;
    else if (load)         sel = SEL_LOAD;
    else if (en_p && en_t) sel = SEL_STEP;
    else                   sel = SEL_HOLD;
  end
endmodule

// File: rtl/chain_next_value.sv
module chain_next_value
  import chain_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit HAS_OFFSETS = 1'b1
) (
  input  next_sel_e        sel,
  input  logic [WIDTH-1:0] count,
  input  logic [WIDTH-1:0] load_val,
  input  logic             at_wrap,
  input  logic             restart_mode,
  input  logic [WIDTH-1:0] start_val,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] wrap_target;

  generate
    if (HAS_OFFSETS) begin : g_restart
      assign wrap_target = restart_mode ? start_val : '0;
    end else begin : g_zero
      logic unused_cfg;
      assign unused_cfg = restart_mode ^ (^start_val);
      assign wrap_target = '0;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_CLEAR: nxt = '0;
      SEL_LOAD:  nxt = load_val;
      SEL_STEP:  nxt = at_wrap ? wrap_target : count + ONE;
      default:   nxt = count;
    endcase
  end
endmodule

// File: rtl/chain_counter.sv
module chain_counter
  import chain_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit HAS_OFFSETS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             en_p,
  input  logic             en_t,
  input  logic             restart_mode,
  input  logic             end_mode,
  input  logic [WIDTH-1:0] start_val,
  input  logic [WIDTH-1:0] end_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  next_sel_e        sel;
  logic             at_wrap;
  logic [WIDTH-1:0] nxt;

  chain_wrap_detect #(.WIDTH(WIDTH), .HAS_OFFSETS(HAS_OFFSETS)) u_wrap (
    .count    (count),
    .end_val  (end_val),
    .end_mode (end_mode),
    .at_wrap  (at_wrap)
  );

  chain_next_select u_sel (
    .rst  (rst),
    .clr  (clr),
    .load (load),
    .en_p (en_p),
    .en_t (en_t),
    .sel  (sel)
  );

  chain_next_value #(.WIDTH(WIDTH), .HAS_OFFSETS(HAS_OFFSETS)) u_next (
    .sel          (sel),
    .count        (count),
    .load_val     (load_val),
    .at_wrap      (at_wrap),
    .restart_mode (restart_mode),
    .start_val    (start_val),
    .nxt          (nxt)
  );

  always_ff @(posedge clk) begin
    count <= nxt;
  end

  assign carry_out = en_t & at_wrap;

  // R1: clear forces zero on the following edge
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R2: load takes priority over counting
  p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && load) |=> (count == $past(load_val)));

  // R3: a low enable freezes the count
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !(en_p && en_t)) |=> $stable(count));

  // R4: away from the wrap point an enabled edge adds one
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && en_p && en_t && !carry_out) |=> (count == $past(count) + ONE));

  // R6: carry never rises without en_t
  p_carry_gate_r6: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> en_t);

  // R5: plain wrap from all ones reaches zero
  p_plain_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && en_p && carry_out && !restart_mode) |=> (count == '0));
endmodule

// File: tb/chain_counter_tb_top.sv
`timescale 1ns/1ps
module chain_counter_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst, clr, load, en_p, en_t, restart_mode, end_mode;
  logic [W-1:0] load_val, start_val, end_val, count;
  logic carry_out;
  logic hi_load;
  logic [W-1:0] hi_load_val, hi_count;
  logic hi_carry;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_lo, exp_hi;

  always #4 clk = ~clk;

  chain_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .load_val(load_val),
    .en_p(en_p), .en_t(en_t), .restart_mode(restart_mode), .end_mode(end_mode),
    .start_val(start_val), .end_val(end_val), .count(count), .carry_out(carry_out));

  chain_counter #(.WIDTH(W)) hi_i (
    .clk(clk), .rst(rst), .clr(clr), .load(hi_load), .load_val(hi_load_val),
    .en_p(1'b1), .en_t(carry_out), .restart_mode(1'b0), .end_mode(1'b0),
    .start_val('0), .end_val('0), .count(hi_count), .carry_out(hi_carry));

  function automatic logic model_wrap(logic [W-1:0] c, logic em, logic [W-1:0] ev);
    return em ? (c == ev) : (c == {W{1'b1}});
  endfunction

  function automatic logic [W-1:0] model_next(logic [W-1:0] c, logic r, logic cl,
      logic ld, logic [W-1:0] lv, logic ep, logic et, logic rm, logic em,
      logic [W-1:0] sv, logic [W-1:0] ev);
    if (r || cl) return '0;
    if (ld) return lv;
    if (!(ep && et)) return c;
    if (model_wrap(c, em, ev)) return rm ? sv : '0;
    return c + W'(1);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven, check carry, predict, advance
  string pend_tag = "R1";
  task automatic cycle();
    string tag;
    #1;
    check("R6 carry", {{(W-1){1'b0}}, carry_out},
          {{(W-1){1'b0}}, en_t && model_wrap(exp_lo, end_mode, end_val)});
    if (rst || clr) tag = "R1";
    else if (load) tag = "R2";
    else if (!(en_p && en_t)) tag = "R3";
    else if (model_wrap(exp_lo, end_mode, end_val))
      tag = end_mode ? "R8" : (restart_mode ? "R7" : "R5");
    else if (end_mode && exp_lo > end_val) tag = "R8";
    else tag = "R4";
    exp_hi = model_next(exp_hi, rst, clr, hi_load, hi_load_val, 1'b1,
                        en_t && model_wrap(exp_lo, end_mode, end_val), 1'b0, 1'b0, '0, '0);
    exp_lo = model_next(exp_lo, rst, clr, load, load_val, en_p, en_t,
                        restart_mode, end_mode, start_val, end_val);
    @(negedge clk);
    check(tag, count, exp_lo);
    check("R9 cascade", hi_count, exp_hi);
  endtask

  task automatic drive(logic c, logic l, logic [W-1:0] lv, logic ep, logic et);
    clr = c; load = l; load_val = lv; en_p = ep; en_t = et; hi_load = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240607));
    rst = 1'b1; drive(1'b0, 1'b0, '0, 1'b0, 1'b0);
    restart_mode = 0; end_mode = 0; start_val = '0; end_val = '0; hi_load_val = '0;
    exp_lo = 'x; exp_hi = 'x;
    @(negedge clk); cycle();
    rst = 1'b0;
    // R2 load with enables low, then R5 plain wrap and carry into high stage (R9)
    drive(1'b0, 1'b1, 4'b1110, 1'b0, 1'b0); cycle();
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) cycle();
    // R3: each enable alone blocks counting
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0); cycle();
    drive(1'b0, 1'b0, '0, 1'b0, 1'b1); cycle();
    // R7 restart at 0110
    restart_mode = 1; start_val = 4'b0110;
    drive(1'b0, 1'b1, 4'b0110, 1'b1, 1'b1); cycle();
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1);
    for (int i = 0; i < 12; i++) cycle();
    // R8 end at 1101 back to zero
    restart_mode = 0; end_mode = 1; end_val = 4'b1101;
    drive(1'b1, 1'b0, '0, 1'b1, 1'b1); cycle();
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1);
    for (int i = 0; i < 17; i++) cycle();
    // R8 above end value rolls through 1111
    end_val = 4'b0011;
    drive(1'b0, 1'b1, 4'b1100, 1'b1, 1'b1); cycle();
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) cycle();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 64 == 0) begin
        restart_mode = 1'($urandom); end_mode = 1'($urandom);
        start_val = W'($urandom); end_val = W'($urandom);
      end
      r = $urandom_range(0, 99);
      drive(r < 2, (r >= 2 && r < 6), W'($urandom), ($urandom_range(0, 9) != 0),
            ($urandom_range(0, 9) != 0));
      hi_load = ($urandom_range(0, 49) == 0);
      hi_load_val = W'($urandom);
      cycle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule